// File: doc/BRIEF.md
# Privileged Interrupt-Enable Control Unit

This unit sits beside the execute stage of a processor core and resolves a small family of system operations against the current privilege level. For each accepted operation it does one of three things. It raises a trap with a class and an identification number. It changes the interrupt control register, either the global interrupt-enable bit, the priority field or the whole word. Or it does nothing beyond what the operation itself implies. The disable-and-read operation also returns the old enable bit as a data value.

The privilege level comes from two bits of the status word. A build parameter selects the architecture revision. The revision sets where the enable bit sits inside the control register, and it decides whether the two newer operations (disable-and-read and restore) exist at all. Some operations can make earlier enable decisions stale. For these the unit raises an exit flag, so that the pipeline leaves the current block and looks at pending interrupts again. Fetch, context saving and trap vectoring are handled elsewhere.

Top module: `irq_gate_ctrl`

## Requirements
- R1: The privilege level is `status_word[11:10]`: 0 is user-0, 1 is user-1, 2 is supervisor. The reserved value 3 is treated exactly like user-0.
- R2: Enable (`op_sel`=0) and disable (`op_sel`=1) set or clear the enable bit in supervisor or user-1. In user-0 they raise trap class 1 with identifier 1, and the control register does not change.
- R3: Disable-and-read (`op_sel`=2), when permitted, returns the enable bit as it was before the operation in `dst_data` bit 0, with all upper bits zero, asserts `dst_valid`, and clears the enable bit.
- R4: With `ARCH_VER`=0, disable-and-read and restore raise trap class 2 with identifier 1 at every privilege level. The revision check takes precedence over the privilege check. With `ARCH_VER`>=1 they follow the user-1 permission rule of R2.
- R5: Restore (`op_sel`=3), when permitted, copies `src_data[0]` into the enable bit.
- R6: Core-register write (`op_sel`=4), priority set (`op_sel`=5) and return-from-monitor (`op_sel`=6) are allowed only in supervisor. Otherwise they raise trap class 1 with identifier 1, and the control register does not change. A permitted return-from-monitor changes nothing here.
- R7: A permitted priority set writes `imm` into control register bits [7:0]. A permitted core-register write to address 0xFE2C loads `src_data` into the whole control register. A core-register write to any other address leaves the control register unchanged.
- R8: A system call (`op_sel`=7) always raises trap class 6 with identifier `imm`, at any privilege level, and changes nothing else.
- R9: `reeval_exit` is asserted for a permitted enable, a permitted restore, and a permitted core-register write to address 0xFE04. It is never asserted together with a trap.
- R10: The enable bit is bit 15 of the control register when `ARCH_VER`>=2, and bit 8 when `ARCH_VER` is 0 or 1.
- R11: All outputs are registered. They reflect an operation in the cycle after `op_valid` is sampled high, and they stay asserted for that one cycle only. While `op_valid` is low, every flag and data output is zero and the control register holds its value.
- R12: After reset the control register and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code (0..7, see requirements) |
| status_word | input | 32 | Current status word; bits 11:10 carry the privilege level |
| imm | input | 8 | Immediate operand (priority value or system-call number) |
| src_data | input | 32 | Source data register |
| csr_addr | input | 16 | Core-register address for the core-register write |
| icr_q | output | 32 | Interrupt control register |
| dst_valid | output | 1 | `dst_data` carries the read-back enable bit |
| dst_data | output | 32 | Zero-extended old enable bit |
| trap_valid | output | 1 | A trap fires for the last operation |
| trap_class | output | 3 | Trap class (1 protection, 2 illegal opcode, 6 system call) |
| trap_tin | output | 8 | Trap identification number |
| reeval_exit | output | 1 | Leave the block and re-evaluate pending interrupts |

## Verification
A wrong permission decision shows up one cycle after the operation in two ways: a missing or spurious `trap_valid`, and a change or non-change of `icr_q`. A misplaced enable bit corrupts a priority or data bit that stays visible on `icr_q` until it is next overwritten. A lost old-value read appears on `dst_data` in that same cycle. For this reason the sweep reloads a known control word before every operation, and it compares every output both in the result cycle and in the idle cycle that follows. The sweep covers all four privilege codes, all eight operations and both enable states, on three revisions side by side.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

  typedef enum logic [2:0] {
    OP_EN      = 3'd0,
    OP_DIS     = 3'd1,
    OP_DIS_RD  = 3'd2,
    OP_RESTORE = 3'd3,
    OP_CSR_WR  = 3'd4,
    OP_PRIO    = 3'd5,
    OP_RFM     = 3'd6,
    OP_SYSCALL = 3'd7
  } irqg_op_e;

  typedef enum logic [1:0] {
    LVL_USER0 = 2'd0,
    LVL_USER1 = 2'd1,
    LVL_SUPER = 2'd2,
    LVL_RSVD  = 2'd3
  } irqg_lvl_e;

  localparam int VER_V13  = 0;
  localparam int VER_V16  = 1;
  localparam int VER_V161 = 2;

  localparam int TIN_W = 8;

  localparam logic [2:0]       TC_PROT  = 3'd1;
  localparam logic [2:0]       TC_IOPC  = 3'd2;
  localparam logic [2:0]       TC_SYS   = 3'd6;
  localparam logic [TIN_W-1:0] TIN_PRIV = 8'd1;
  localparam logic [TIN_W-1:0] TIN_IOPC = 8'd1;

  typedef struct packed {
    logic             trap;
    logic [2:0]       tclass;
    logic [TIN_W-1:0] tin;
    logic             ie_wr;
    logic             ie_val;
    logic             icr_load;
    logic             prio_wr;
    logic             rd_ie;
    logic             exit_req;
  } irqg_act_t;

  // Revision-dependent bit offset of the global enable
  function automatic int ie_bit_pos(int ver);
    return (ver >= VER_V161) ? 15 : 8;
  endfunction

  // Reserved encoding folds onto the least privileged level
  function automatic irqg_lvl_e level_of(logic [1:0] field);
    return (field == 2'd3) ? LVL_USER0 : irqg_lvl_e'(field);
  endfunction

  function automatic irqg_act_t trap_act(logic [2:0] cls, logic [TIN_W-1:0] tin);
    irqg_act_t a;
    a        = '0;
    a.trap   = 1'b1;
    a.tclass = cls;
    a.tin    = tin;
    return a;
  endfunction

endpackage

// File: rtl/irqg_priv_check.sv
module irqg_priv_check
  import irqg_pkg::*;
(
  input  logic [1:0] prv_field,
  output irqg_lvl_e  lvl,
  output logic       is_user0,
  output logic       user1_ok,
  output logic       super_ok
);

  always_comb begin
    lvl      = level_of(prv_field);
    is_user0 = (lvl == LVL_USER0);
    super_ok = (lvl == LVL_SUPER);
    user1_ok = (lvl == LVL_SUPER) || (lvl == LVL_USER1);
  end

  // R1: levels partition cleanly, reserved code never grants rights
  always_comb begin
    a_lvl_partition_r1: assert ($onehot({is_user0, user1_ok && !super_ok, super_ok}));
  end

endmodule

// File: rtl/irqg_decode.sv
module irqg_decode
  import irqg_pkg::*;
#(
  parameter int              ARCH_VER    = VER_V161,
  parameter int              ADDR_W      = 16,
  parameter int              IMM_W       = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] ICR_ADDR    = 16'hFE2C
) (
  input  logic              op_valid,
  input  irqg_op_e          op,
  input  logic              user1_ok,
  input  logic              super_ok,
  input  logic [IMM_W-1:0]  imm,
  input  logic              src_bit0,
  input  logic [ADDR_W-1:0] addr,
  output irqg_act_t         act
);

  localparam bit NEW_OPS_OK = (ARCH_VER >= VER_V16);

  always_comb begin
    act = '0;
    if (op_valid) begin
      case (op)
        OP_EN: begin
          if (!user1_ok) act = trap_act(TC_PROT, TIN_PRIV);
          else begin
            act.ie_wr    = 1'b1;
            act.ie_val   = 1'b1;
            act.exit_req = 1'b1;
          end
        end
        OP_DIS: begin
          if (!user1_ok) act = trap_act(TC_PROT, TIN_PRIV);
          else begin
            act.ie_wr  = 1'b1;
            act.ie_val = 1'b0;
          end
        end
        OP_DIS_RD: begin
          if (!NEW_OPS_OK)    act = trap_act(TC_IOPC, TIN_IOPC);
          else if (!user1_ok) act = trap_act(TC_PROT, TIN_PRIV);
          else begin
            act.rd_ie  = 1'b1;
            act.ie_wr  = 1'b1;
            act.ie_val = 1'b0;
          end
        end
        OP_RESTORE: begin
          if (!NEW_OPS_OK)    act = trap_act(TC_IOPC, TIN_IOPC);
          else if (!user1_ok) act = trap_act(TC_PROT, TIN_PRIV);
          else begin
            act.ie_wr    = 1'b1;
            act.ie_val   = src_bit0;
            act.exit_req = 1'b1;
          end
        end
        OP_CSR_WR: begin
          if (!super_ok) act = trap_act(TC_PROT, TIN_PRIV);
          else begin
            act.exit_req = (addr == STATUS_ADDR);
            act.icr_load = (addr == ICR_ADDR);
          end
        end
        OP_PRIO: begin
          if (!super_ok) act = trap_act(TC_PROT, TIN_PRIV);
          else act.prio_wr = 1'b1;
        end
        OP_RFM: begin
          if (!super_ok) act = trap_act(TC_PROT, TIN_PRIV);
        end
        OP_SYSCALL: act = trap_act(TC_SYS, TIN_W'(imm));
        default: act = '0;
      endcase
    end
  end

  // R9: a trap never carries a state change or an exit request
  always_comb begin
    a_trap_no_effect_r9: assert (!(act.trap && (act.exit_req || act.ie_wr || act.icr_load || act.prio_wr || act.rd_ie)));
  end

endmodule

// File: rtl/irqg_icr_reg.sv
module irqg_icr_reg
  import irqg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int IE_POS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irqg_act_t         act,
  input  logic [DATA_W-1:0] src_data,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] icr_q,
  output logic              ie_now
);

  function automatic logic [DATA_W-1:0] icr_next(
    logic [DATA_W-1:0] cur, irqg_act_t a,
    logic [DATA_W-1:0] src, logic [IMM_W-1:0] prio);
    logic [DATA_W-1:0] n;
    n = cur;
    if (a.icr_load) n = src;
    if (a.prio_wr)  n[IMM_W-1:0] = prio;
    if (a.ie_wr)    n[IE_POS] = a.ie_val;
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) icr_q <= '0;
    else        icr_q <= icr_next(icr_q, act, src_data, imm);
  end

  assign ie_now = icr_q[IE_POS];

  // R2: a permitted enable or disable lands in the enable bit
  p_ie_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act.ie_wr) |-> (icr_q[IE_POS] == $past(act.ie_val)));

  // R3: after disable-and-read the enable bit is clear
  p_ie_clear_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act.rd_ie) |-> !icr_q[IE_POS]);

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irqg_pkg::*;
#(
  parameter int              ARCH_VER    = VER_V161,
  parameter int              DATA_W      = 32,
  parameter int              IMM_W       = 8,
  parameter int              ADDR_W      = 16,
  parameter int              PRV_LSB     = 10,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] ICR_ADDR    = 16'hFE2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] status_word,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] src_data,
  input  logic [ADDR_W-1:0] csr_addr,
  output logic [DATA_W-1:0] icr_q,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data,
  output logic              trap_valid,
  output logic [2:0]        trap_class,
  output logic [TIN_W-1:0]  trap_tin,
  output logic              reeval_exit
);

  localparam int IE_POS = ie_bit_pos(ARCH_VER);

  irqg_lvl_e lvl;
  logic      is_user0, user1_ok, super_ok, ie_now;
  irqg_act_t act;
  logic      unused_status;

  assign unused_status = ^status_word;

  irqg_priv_check u_priv (
    .prv_field (status_word[PRV_LSB+1:PRV_LSB]),
    .lvl       (lvl),
    .is_user0  (is_user0),
    .user1_ok  (user1_ok),
    .super_ok  (super_ok)
  );

  irqg_decode #(
    .ARCH_VER    (ARCH_VER),
    .ADDR_W      (ADDR_W),
    .IMM_W       (IMM_W),
    .STATUS_ADDR (STATUS_ADDR),
    .ICR_ADDR    (ICR_ADDR)
  ) u_dec (
    .op_valid (op_valid),
    .op       (irqg_op_e'(op_sel)),
    .user1_ok (user1_ok),
    .super_ok (super_ok),
    .imm      (imm),
    .src_bit0 (src_data[0]),
    .addr     (csr_addr),
    .act      (act)
  );

  irqg_icr_reg #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .IE_POS (IE_POS)
  ) u_icr (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .src_data (src_data),
    .imm      (imm),
    .icr_q    (icr_q),
    .ie_now   (ie_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_valid  <= 1'b0;
      trap_class  <= '0;
      trap_tin    <= '0;
      dst_valid   <= 1'b0;
      dst_data    <= '0;
      reeval_exit <= 1'b0;
    end else begin
      trap_valid  <= act.trap;
      trap_class  <= act.tclass;
      trap_tin    <= act.tin;
      dst_valid   <= act.rd_ie;
      dst_data    <= act.rd_ie ? DATA_W'(ie_now) : '0;
      reeval_exit <= act.exit_req;
    end
  end

  // R11: a trap only follows an accepted operation
  p_trap_needs_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(op_valid));

  // R2 / R6: a trapping operation leaves the control register alone
  p_icr_hold_on_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $stable(icr_q));

  // R1: user-0 (and reserved) can never modify the control register
  p_user0_icr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && is_user0) |-> $stable(icr_q));

  // R9: exit request is exclusive with a trap
  p_exit_excl_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reeval_exit |-> !trap_valid);

  // R8: system-call identifier is the immediate of that operation
  p_syscall_tin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_class == TC_SYS) |-> (trap_tin == TIN_W'($past(imm))));

  // R3: read-back value is zero-extended
  p_dst_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> (dst_data[DATA_W-1:1] == '0));

endmodule

// File: tb/irq_gate_ctrl_bench.sv
module irq_gate_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] status_word = '0;
  logic [7:0]  imm = '0;
  logic [31:0] src_data = '0;
  logic [15:0] csr_addr = '0;

  logic [31:0] icr_o  [3];
  logic        dv_o   [3];
  logic [31:0] dst_o  [3];
  logic        trap_o [3];
  logic [2:0]  cls_o  [3];
  logic [7:0]  tin_o  [3];
  logic        exit_o [3];

  // expected state per instance: 0 -> revision 2, 1 -> revision 1, 2 -> revision 0
  int          vers [3] = '{2, 1, 0};
  logic [31:0] e_icr  [3];
  logic        e_dv   [3];
  logic [31:0] e_dst  [3];
  logic        e_trap [3];
  logic [2:0]  e_cls  [3];
  logic [7:0]  e_tin  [3];
  logic        e_exit [3];

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  irq_gate_ctrl #(.ARCH_VER(2)) u_irq_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .status_word(status_word), .imm(imm), .src_data(src_data), .csr_addr(csr_addr),
    .icr_q(icr_o[0]), .dst_valid(dv_o[0]), .dst_data(dst_o[0]), .trap_valid(trap_o[0]),
    .trap_class(cls_o[0]), .trap_tin(tin_o[0]), .reeval_exit(exit_o[0]));

  irq_gate_ctrl #(.ARCH_VER(1)) u_v16 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .status_word(status_word), .imm(imm), .src_data(src_data), .csr_addr(csr_addr),
    .icr_q(icr_o[1]), .dst_valid(dv_o[1]), .dst_data(dst_o[1]), .trap_valid(trap_o[1]),
    .trap_class(cls_o[1]), .trap_tin(tin_o[1]), .reeval_exit(exit_o[1]));

  irq_gate_ctrl #(.ARCH_VER(0)) u_v13 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .status_word(status_word), .imm(imm), .src_data(src_data), .csr_addr(csr_addr),
    .icr_q(icr_o[2]), .dst_valid(dv_o[2]), .dst_data(dst_o[2]), .trap_valid(trap_o[2]),
    .trap_class(cls_o[2]), .trap_tin(tin_o[2]), .reeval_exit(exit_o[2]));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  task automatic compare(int i, string tag);
    logic [77:0] act_v, exp_v;
    act_v = {icr_o[i], trap_o[i], cls_o[i], tin_o[i], dv_o[i], dst_o[i], exit_o[i]};
    exp_v = {e_icr[i], e_trap[i], e_cls[i], e_tin[i], e_dv[i], e_dst[i], e_exit[i]};
    n_checks++;
    if (act_v !== exp_v) begin
      n_errors++;
      $display("FAIL %s inst=%0d actual=%h expected=%h", tag, i, act_v, exp_v);
    end
  endtask

  function automatic void clear_pulses(int i);
    e_trap[i] = 1'b0; e_cls[i] = '0; e_tin[i] = '0;
    e_dv[i] = 1'b0; e_dst[i] = '0; e_exit[i] = 1'b0;
  endfunction

  // Independent model of the requirements
  function automatic void model(int i, int op, int prv, logic [7:0] im,
                                logic [31:0] src, logic [15:0] ad);
    int  pos  = (vers[i] >= 2) ? 15 : 8;            // R10
    bit  lo   = (prv == 0) || (prv == 3);           // R1: 3 behaves as user-0
    bit  sup  = (prv == 2);
    bit  newop = (vers[i] >= 1);                    // R4
    clear_pulses(i);
    if (op == 7) begin                              // R8
      e_trap[i] = 1'b1; e_cls[i] = 3'd6; e_tin[i] = im;
    end else if ((op == 2 || op == 3) && !newop) begin
      e_trap[i] = 1'b1; e_cls[i] = 3'd2; e_tin[i] = 8'd1;
    end else if ((op <= 3 && lo) || (op >= 4 && !sup)) begin
      e_trap[i] = 1'b1; e_cls[i] = 3'd1; e_tin[i] = 8'd1;
    end else begin
      case (op)
        0: begin e_icr[i][pos] = 1'b1; e_exit[i] = 1'b1; end
        1: e_icr[i][pos] = 1'b0;
        2: begin e_dv[i] = 1'b1; e_dst[i] = {31'd0, e_icr[i][pos]}; e_icr[i][pos] = 1'b0; end
        3: begin e_icr[i][pos] = src[0]; e_exit[i] = 1'b1; end
        4: begin
             if (ad == 16'hFE04) e_exit[i] = 1'b1;
             if (ad == 16'hFE2C) e_icr[i] = src;
           end
        5: e_icr[i][7:0] = im;
        default: ;
      endcase
    end
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1: return "R2";
      2:    return "R3";
      3:    return "R5";
      4, 6: return "R6";
      5:    return "R7";
      default: return "R8";
    endcase
  endfunction

  // Drive at falling edge, sample result one falling edge later (R11),
  // then confirm everything drops in the following idle cycle.
  task automatic apply(int op, int prv, logic [7:0] im, logic [31:0] src,
                       logic [15:0] ad, string tag);
    @(negedge clk);
    op_sel = 3'(op); status_word = 32'hFFFF_F3FF | (32'(prv) << 10);
    status_word[11:10] = 2'(prv);
    imm = im; src_data = src; csr_addr = ad; op_valid = 1'b1;
    for (int i = 0; i < 3; i++) model(i, op, prv, im, src, ad);
    @(negedge clk);
    op_valid = 1'b0;
    for (int i = 0; i < 3; i++) compare(i, tag);
    for (int i = 0; i < 3; i++) clear_pulses(i);
    @(negedge clk);
    for (int i = 0; i < 3; i++) compare(i, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin e_icr[i] = '0; clear_pulses(i); end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) compare(i, "R12");   // reset state

    // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10: full sweep of level x operation x enable state
    for (int prv = 0; prv < 4; prv++) begin
      for (int op = 0; op < 8; op++) begin
        for (int pre = 0; pre < 2; pre++) begin
          logic [31:0] pat;
          logic [15:0] ad;
          logic [7:0]  im;
          pat = 32'h3C5A_0000 ^ (32'(op) * 32'h0101_0011) ^ (32'(prv) << 20);
          pat[15] = pre[0];
          pat[8]  = pre[0];
          // preload via supervisor write to the control register address (R7)
          apply(4, 2, 8'h00, pat, 16'hFE2C, "R7");
          im = 8'((prv * 8 + op) * 29 + 3 + pre * 64);
          case ((op + prv + pre) % 3)
            0:       ad = 16'hFE04;                     // R9 status address
            1:       ad = 16'hFE2C;
            default: ad = 16'h1234;
          endcase
          apply(op, prv, im, {~pat[31:1], ~pre[0]}, ad, tag_of(op));
        end
      end
    end

    // R9: status-register write from supervisor requests exit, not from user-1
    apply(4, 2, 8'h00, 32'h0, 16'hFE04, "R9");
    apply(4, 1, 8'h00, 32'h0, 16'hFE04, "R9");
    // R3 back-to-back: second disable-and-read sees the cleared bit
    apply(0, 1, 8'h00, 32'h0, 16'h0, "R2");
    apply(2, 2, 8'h00, 32'h0, 16'h0, "R3");
    apply(2, 2, 8'h00, 32'h0, 16'h0, "R3");

    summary();
    $finish;
  end

endmodule